// File: doc/BRIEF.md
# CRC-Checked Register Write Engine

This block consumes the byte stream of a write transaction delivered by an I2C target byte front end. The stream is a start marker, then an address byte and a pointer byte, then 16-bit words, each sent as a high byte followed by a low byte. The block drives the acknowledge bit for each byte. It produces a one-cycle write strobe with address and data for every word it accepts, and moving the write pointer forward after each word is optional.

When integrity checking is enabled, a CRC-8 byte follows each protected group. The first CRC covers the address byte, the pointer byte and the first word, and it decides the fate of the whole transaction. Each later word carries its own CRC over just its two bytes, and that CRC decides only the fate of that word. A failing CRC produces a NACK and raises a sticky error flag. A transaction that ends before a pending word's CRC arrives drops that word quietly.

Top module: `crc_wr_engine`

## Requirements
- R1: With `crc_en_i` low, each word is written with no CRC byte. `wr_en_o` pulses in the cycle after the low byte is sampled, and `wr_data_o` holds {high byte, low byte}.
- R2: With `auto_inc_i` high, the address of each word slot is one more than the previous slot's address, starting at the pointer byte's low `AW` bits. With `auto_inc_i` low, every word in the transaction targets the pointer address.
- R3: With checking on, the first CRC byte is compared to a CRC-8 taken over the address, pointer, high and low bytes. The CRC uses polynomial 0x07, shifts MSB first and starts from 0x00. On a match the word is written and the CRC byte is ACKed.
- R4: Every CRC byte after the first is compared to a CRC-8, starting from 0x00, over only the two data bytes of its own word.
- R5: If the first CRC fails, nothing further is written in that transaction, even when the later CRCs are correct.
- R6: A failing later CRC drops only its own word. The pointer still advances, so the next words land at their intended addresses.
- R7: A CRC mismatch returns NACK (`ack_o` = 0) for that CRC byte and sets `crc_err_o`.
- R8: `crc_err_o` stays set until `flag_clr_i` is pulsed or reset is applied. When a new failure and a clear arrive in the same cycle, the failure wins.
- R9: If a stop or start arrives before the CRC byte of a pending word, that word is not written and `crc_err_o` is not set.
- R10: With checking on and `auto_inc_i` low, only the first word that passes is written. Later words to the same register are dropped without setting the flag.
- R11: Address, pointer and data bytes are always ACKed. `ack_o` is registered and reflects the byte sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or repeated start seen on the bus |
| stop_i | input | 1 | Stop seen on the bus |
| byte_valid_i | input | 1 | One-cycle strobe: a received byte is on `byte_data_i` |
| byte_data_i | input | 8 | Received byte |
| crc_en_i | input | 1 | Integrity checking enable, held stable during a transaction |
| auto_inc_i | input | 1 | Pointer auto-increment enable |
| flag_clr_i | input | 1 | Clears the CRC error flag |
| ack_o | output | 1 | Acknowledge for the last sampled byte (1 = ACK) |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | AW | Register write address |
| wr_data_o | output | 16 | Register write data |
| crc_err_o | output | 1 | Sticky CRC error flag |

## Verification
The first input pattern is plain writes without CRC, with the pointer both stepping and fixed; it separates word assembly from address stepping. Fully valid checked transactions then confirm that the first CRC spans four bytes and each later CRC spans only two. A corrupted first CRC and a corrupted middle CRC tell the transaction-wide gate apart from the per-word drop. Transactions cut off before a CRC byte, and checked writes that repeat one register, show which drops are silent and leave the flag untouched.

// File: rtl/crc_wr_pkg.sv
package crc_wr_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_MSB, ST_LSB, ST_CRC
  } wr_state_e;

  function automatic logic [7:0] crc8_upd(input logic [7:0] crc,
                                          input logic [7:0] data,
                                          input logic [7:0] poly);
    logic [7:0] c;
    c = crc ^ data;
    for (int i = 0; i < 8; i++)
      c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/crc8_acc.sv
module crc8_acc #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic       restart_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  import crc_wr_pkg::*;

  logic [7:0] base;
  assign base = restart_i ? 8'h00 : crc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_o <= 8'h00;
    else if (clr_i)   crc_o <= 8'h00;
    else if (upd_i)   crc_o <= crc8_upd(base, data_i, POLY);
  end

  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !upd_i) |=> $stable(crc_o)); // R4
endmodule

// File: rtl/wr_ptr.sv
module wr_ptr #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          inc_en_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ptr_o <= '0;
    else if (load_i)             ptr_o <= load_val_i;
    else if (step_i && inc_en_i) ptr_o <= ptr_o + 1'b1;
  end

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && inc_en_i && !load_i) |=> (ptr_o == $past(ptr_o) + 1'b1)); // R2
endmodule

// File: rtl/crc_wr_engine.sv
module crc_wr_engine
  import crc_wr_pkg::*;
#(
  parameter int         AW   = 4,
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  input  logic              crc_en_i,
  input  logic              auto_inc_i,
  input  logic              flag_clr_i,
  output logic              ack_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              crc_err_o
);
  wr_state_e  st_q;
  logic [7:0] msb_q, lsb_q, crc_q;
  logic [AW-1:0] ptr_q;
  logic first_q, bad_q, wrote_q;
  logic take, crc_ok, word_done, dup_block, commit, fail;
  logic crc_upd, crc_restart, crc_clr, ptr_load;

  assign take        = byte_valid_i && !start_i && !stop_i;
  assign crc_restart = take && (st_q == ST_ADDR);
  assign crc_upd     = take && (st_q inside {ST_ADDR, ST_PTR, ST_MSB, ST_LSB});
  assign crc_clr     = take && (st_q == ST_CRC);
  assign ptr_load    = take && (st_q == ST_PTR);
  assign crc_ok      = (byte_data_i == crc_q);
  assign word_done   = take && ((st_q == ST_LSB && !crc_en_i) || st_q == ST_CRC);
  // repeated same-register writes under CRC: keep the first only
  assign dup_block   = crc_en_i && !auto_inc_i && wrote_q;
  assign fail        = take && (st_q == ST_CRC) && !crc_ok;
  assign commit      = word_done && !bad_q && !dup_block && (st_q == ST_LSB || crc_ok);

  crc8_acc #(.POLY(POLY)) u_crc (
    .clk_i, .rst_ni,
    .clr_i(crc_clr), .upd_i(crc_upd), .restart_i(crc_restart),
    .data_i(byte_data_i), .crc_o(crc_q)
  );

  wr_ptr #(.AW(AW)) u_ptr (
    .clk_i, .rst_ni,
    .load_i(ptr_load), .load_val_i(byte_data_i[AW-1:0]),
    .step_i(word_done), .inc_en_i(auto_inc_i), .ptr_o(ptr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      msb_q   <= '0;
      lsb_q   <= '0;
      first_q <= 1'b0;
      bad_q   <= 1'b0;
      wrote_q <= 1'b0;
    end else if (start_i) begin
      st_q    <= ST_ADDR;
      first_q <= 1'b1;
      bad_q   <= 1'b0;
      wrote_q <= 1'b0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
    end else if (take) begin
      if (commit) wrote_q <= 1'b1;
      unique case (st_q)
        ST_ADDR: st_q <= ST_PTR;
        ST_PTR:  st_q <= ST_MSB;
        ST_MSB: begin
          msb_q <= byte_data_i;
          st_q  <= ST_LSB;
        end
        ST_LSB: begin
          lsb_q <= byte_data_i;
          if (crc_en_i) st_q <= ST_CRC;
          else begin
            st_q    <= ST_MSB;
            first_q <= 1'b0;
          end
        end
        ST_CRC: begin
          if (fail && first_q) bad_q <= 1'b1;
          first_q <= 1'b0;
          st_q    <= ST_MSB;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o     <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      crc_err_o <= 1'b0;
    end else begin
      wr_en_o <= commit;
      if (commit) begin
        wr_addr_o <= ptr_q;
        wr_data_o <= (st_q == ST_LSB) ? {msb_q, byte_data_i} : {msb_q, lsb_q};
      end
      if (take) ack_o <= (st_q != ST_IDLE) && !fail;
      if (fail)            crc_err_o <= 1'b1;
      else if (flag_clr_i) crc_err_o <= 1'b0;
    end
  end

  AST_WR_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ack_o); // R7
  AST_WR_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(byte_valid_i)); // R1
  AST_FLAG_ON_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_err_o) |-> !ack_o); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_err_o && !flag_clr_i) |=> crc_err_o); // R8
endmodule

// File: tb/sim_crc_wr_engine.sv
module sim_crc_wr_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, bv = 0, crc_en = 0, auto_inc = 1, clr = 0;
  logic [7:0] bd = '0;
  logic ack, wr_en, err;
  logic [3:0] wr_addr;
  logic [15:0] wr_data;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  bit done = 0;
  logic [3:0]  log_a [64];
  logic [15:0] log_d [64];

  always #2 clk = ~clk;

  crc_wr_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_valid_i(bv), .byte_data_i(bd), .crc_en_i(crc_en),
    .auto_inc_i(auto_inc), .flag_clr_i(clr), .ack_o(ack), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .crc_err_o(err)
  );

  always @(negedge clk) if (wr_en && wr_cnt < 64) begin
    log_a[wr_cnt] = wr_addr;
    log_d[wr_cnt] = wr_data;
    wr_cnt++;
  end

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ b[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, output logic a);
    @(negedge clk); bv = 1; bd = b;
    @(negedge clk); bv = 0;
    a = ack;
  endtask

  task automatic pulse_start(); @(negedge clk); start = 1; @(negedge clk); start = 0; endtask
  task automatic pulse_stop();  @(negedge clk); stop = 1;  @(negedge clk); stop = 0;  endtask

  task automatic chk_wr(input int idx, input logic [3:0] a, input logic [15:0] d, input string req);
    check(log_a[idx] == a, req, log_a[idx], a);
    check(log_d[idx] == d, req, log_d[idx], d);
  endtask

  // header with first word and first CRC; returns ack of CRC byte
  task automatic hdr_crc(input logic [7:0] p, input logic [15:0] w, input logic [7:0] flip, output logic a);
    logic [7:0] c; logic x;
    c = ref_crc(ref_crc(ref_crc(ref_crc(8'h00, 8'h90), p), w[15:8]), w[7:0]);
    pulse_start();
    send(8'h90, x); send(p, x); send(w[15:8], x); send(w[7:0], x);
    send(c ^ flip, a);
  endtask

  task automatic word_crc(input logic [15:0] w, input logic [7:0] flip, output logic a);
    logic [7:0] c; logic x;
    c = ref_crc(ref_crc(8'h00, w[15:8]), w[7:0]);
    send(w[15:8], x); send(w[7:0], x);
    send(c ^ flip, a);
  endtask

  task automatic t_reset();
    check(wr_en == 0, "reset wr_en", wr_en, 0);
    check(err == 0, "reset err", err, 0);
    check(ack == 0, "reset ack", ack, 0);
  endtask

  task automatic t_plain();
    logic a; int b0;
    crc_en = 0; auto_inc = 1; b0 = wr_cnt;
    pulse_start();
    send(8'h90, a); check(a == 1, "R11 addr ack", a, 1);
    send(8'h03, a); check(a == 1, "R11 ptr ack", a, 1);
    send(8'h12, a); send(8'h34, a); check(a == 1, "R11 data ack", a, 1);
    send(8'hab, a); send(8'hcd, a);
    pulse_stop();
    check(wr_cnt - b0 == 2, "R1 write count", wr_cnt - b0, 2);
    chk_wr(b0, 4'h3, 16'h1234, "R1 word0");
    chk_wr(b0 + 1, 4'h4, 16'habcd, "R2 inc addr");
    auto_inc = 0; b0 = wr_cnt;
    pulse_start();
    send(8'h90, a); send(8'h05, a);
    send(8'h11, a); send(8'h22, a); send(8'h33, a); send(8'h44, a);
    pulse_stop();
    check(wr_cnt - b0 == 2, "R2 fixed count", wr_cnt - b0, 2);
    chk_wr(b0, 4'h5, 16'h1122, "R2 fixed0");
    chk_wr(b0 + 1, 4'h5, 16'h3344, "R2 fixed1");
    auto_inc = 1;
  endtask

  task automatic t_crc_good();
    logic a; int b0;
    crc_en = 1; b0 = wr_cnt;
    hdr_crc(8'h03, 16'hbeef, 8'h00, a); check(a == 1, "R3 first crc ack", a, 1);
    word_crc(16'h5a0f, 8'h00, a);       check(a == 1, "R4 word crc ack", a, 1);
    pulse_stop();
    check(wr_cnt - b0 == 2, "R3 count", wr_cnt - b0, 2);
    chk_wr(b0, 4'h3, 16'hbeef, "R3 word");
    chk_wr(b0 + 1, 4'h4, 16'h5a0f, "R4 word");
    check(err == 0, "R3 no flag", err, 0);
  endtask

  task automatic t_later_bad();
    logic a; int b0;
    crc_en = 1; b0 = wr_cnt;
    hdr_crc(8'h03, 16'h0303, 8'h00, a);
    word_crc(16'h0404, 8'h5a, a); check(a == 0, "R7 nack", a, 0);
    check(err == 1, "R7 flag set", err, 1);
    word_crc(16'h0505, 8'h00, a); check(a == 1, "R6 next ack", a, 1);
    pulse_stop();
    check(wr_cnt - b0 == 2, "R6 count", wr_cnt - b0, 2);
    chk_wr(b0, 4'h3, 16'h0303, "R6 first kept");
    chk_wr(b0 + 1, 4'h5, 16'h0505, "R6 third kept");
    check(err == 1, "R8 sticky", err, 1);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    check(err == 0, "R8 cleared", err, 0);
  endtask

  task automatic t_first_bad();
    logic a; int b0;
    crc_en = 1; b0 = wr_cnt;
    hdr_crc(8'h02, 16'hc0de, 8'h01, a); check(a == 0, "R7 first nack", a, 0);
    word_crc(16'h7777, 8'h00, a);
    pulse_stop();
    check(wr_cnt == b0, "R5 no writes", wr_cnt - b0, 0);
    check(err == 1, "R5 flag", err, 1);
    // fail and clear together: fail wins
    pulse_start();
    begin logic x; send(8'h90, x); send(8'h01, x); send(8'h00, x); send(8'h00, x); end
    @(negedge clk); clr = 1; bv = 1; bd = 8'hff;
    @(negedge clk); clr = 0; bv = 0;
    check(err == 1, "R8 set wins", err, 1);
    pulse_stop();
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic t_missing();
    logic a; int b0;
    crc_en = 1; b0 = wr_cnt;
    pulse_start();
    send(8'h90, a); send(8'h07, a); send(8'h12, a); send(8'h34, a);
    pulse_stop();
    check(wr_cnt == b0, "R9 no write", wr_cnt - b0, 0);
    check(err == 0, "R9 no flag", err, 0);
    hdr_crc(8'h08, 16'h8888, 8'h00, a);
    send(8'h99, a); send(8'h99, a);
    pulse_start(); pulse_stop();
    check(wr_cnt - b0 == 1, "R9 only first", wr_cnt - b0, 1);
    chk_wr(b0, 4'h8, 16'h8888, "R9 first word");
    check(err == 0, "R9 flag clear", err, 0);
  endtask

  task automatic t_same_reg();
    logic a; int b0;
    crc_en = 1; auto_inc = 0; b0 = wr_cnt;
    hdr_crc(8'h06, 16'h6001, 8'h00, a);
    word_crc(16'h6002, 8'h00, a); check(a == 1, "R10 ack", a, 1);
    pulse_stop();
    check(wr_cnt - b0 == 1, "R10 count", wr_cnt - b0, 1);
    chk_wr(b0, 4'h6, 16'h6001, "R10 first");
    check(err == 0, "R10 no flag", err, 0);
    auto_inc = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_crc_good();
    t_later_bad();
    t_first_bad();
    t_missing();
    t_same_reg();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule